// File: doc/BRIEF.md
# SDRAM Device Command Decoder

This block is the command-interpreting front end of a behavioural synchronous DRAM device. It can serve as a memory-side model or as a synthesizable protocol checker placed beside a controller. On every rising clock edge it samples clock enable, chip select, the three strobes, the bank address, the auto-precharge address bit and the data mask. From these it works out which operation the controller requested, and it keeps a record of which banks hold an open row. It also tracks whether the device is running normally, powered down, clock-suspended or in self refresh.

The meaning of a pin pattern depends on the clock-enable level in the previous and the current cycle, on the bank state and on whether a burst is in flight. A single strobe pattern can therefore mean auto refresh or self-refresh entry. A quiet pattern on a falling clock enable can mean power-down or clock suspend. The decoder reports every command it sees. A command that is illegal in the current state raises an error pulse and leaves the bank record alone. A burst tracker and a data-mask pipeline turn the mask pin into a read-output enable and a write-byte mask. The storage array and the data-path timing lie outside this block.

Top module: `sdcmd_decoder`

## Requirements
- R1: Commands are decoded from {cs_n,ras_n,cas_n,we_n}: 1xxx deselect (op 0), 0111 no-op (1), 0011 activate (2), 0101 read (3, or 4 with a10), 0100 write (5, or 6 with a10), 0010 precharge (7, or 8 with a10), 0001 refresh (9), 0000 mode set (10), 0110 burst stop (11). `op_code` shows the decode one cycle after the sampling edge.
- R2: Activate is legal only for an idle bank. Read and write are legal only for an active bank. An illegal command leaves `bank_active` unchanged.
- R3: With clock enable high in both cycles, the refresh pattern is auto refresh (op 9) and is legal only when every bank is idle.
- R4: With clock enable high then low, the refresh pattern is self-refresh entry (op 12, `pwr_state` 3). It is legal only with all banks idle and no burst running. An illegal entry reports an error and falls back to power-down or suspend.
- R5: Clock enable rising ends any low-power state (`pwr_state` 0). The op is 13 from self refresh, 15 from power-down and 17 from suspend. The exit is legal only with a deselect or no-op. While clock enable stays low the op is 18 and commands are ignored.
- R6: Clock enable falling with a deselect or no-op enters power-down (op 14, `pwr_state` 1) when no burst runs, or clock suspend (op 16, `pwr_state` 2) when one runs. The burst position freezes while suspended.
- R7: A precharge with a10 high closes every bank. With a10 low it closes only the addressed bank.
- R8: A read or write with a10 high closes its bank at the edge where that burst ends. A read, write or precharge aimed at a bank still waiting for this is illegal.
- R9: Mode set is legal only when every bank is idle.
- R10: During a read burst, `rd_oe` is low exactly two cycles after a cycle in which `dqm` was high.
- R11: During a write burst, `wr_mask` follows `dqm` in the same cycle, with no latency.
- R12: `op_err` is high for one cycle for each illegal command. A legal command clears it.
- R13: In reset, all banks are idle, `pwr_state` is 0, `op_code` is 0 and `op_err`, `burst_busy`, `rd_oe` and `wr_mask` are 0.
- R14: A read or write makes `burst_busy` high for BURST_LEN cycles after its sampling edge. A burst stop ends the burst at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cke | input | 1 | Clock enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write strobe, active low |
| ba | input | $clog2(NBANK) | Bank address |
| a10 | input | 1 | Auto-precharge / all-banks select |
| dqm | input | 1 | Data mask |
| op_code | output | 5 | Decoded operation of the last sampled edge |
| op_err | output | 1 | Illegal-command pulse |
| bank_active | output | NBANK | One bit per bank, set while a row is open |
| pwr_state | output | 2 | 0 normal, 1 power-down, 2 suspend, 3 self refresh |
| burst_busy | output | 1 | A read or write burst is in flight |
| rd_oe | output | 1 | Read data output enable after masking |
| wr_mask | output | 1 | Write data byte mask for the current cycle |

## Verification
The assertions take the strobe and clock-enable pins to be stable levels around each rising edge. They also take the low-power states to be entered and left only through clock-enable transitions. This is what keeps the power-state register and the stored previous clock-enable level in step. The stimulus changes every input on the falling edge, one command per cycle. It holds the data mask low except where a masking case is under test. The check that an error leaves the bank record alone is limited to cycles with no burst in flight before the edge, because an auto-precharge can legitimately close a bank during the same edge.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

   typedef enum logic [3:0] {
      K_DESEL, K_NOP, K_ACT, K_RD, K_WR, K_PRE, K_REF, K_MRS, K_BST
   } kind_t;

   typedef enum logic [4:0] {
      OP_DESEL    = 5'd0,
      OP_NOP      = 5'd1,
      OP_ACT      = 5'd2,
      OP_RD       = 5'd3,
      OP_RDA      = 5'd4,
      OP_WR       = 5'd5,
      OP_WRA      = 5'd6,
      OP_PRE      = 5'd7,
      OP_PREA     = 5'd8,
      OP_REF      = 5'd9,
      OP_MRS      = 5'd10,
      OP_BST      = 5'd11,
      OP_SREF_IN  = 5'd12,
      OP_SREF_OUT = 5'd13,
      OP_PD_IN    = 5'd14,
      OP_PD_OUT   = 5'd15,
      OP_SUSP_IN  = 5'd16,
      OP_SUSP_OUT = 5'd17,
      OP_HOLD     = 5'd18
   } op_t;

   typedef enum logic [1:0] {
      PW_NORMAL  = 2'd0,
      PW_PDOWN   = 2'd1,
      PW_SUSPEND = 2'd2,
      PW_SELFREF = 2'd3
   } pwr_t;

endpackage

// File: rtl/sdcmd_classify.sv
module sdcmd_classify import sdcmd_pkg::*; (
   input  logic  cs_n,
   input  logic  ras_n,
   input  logic  cas_n,
   input  logic  we_n,
   output kind_t kind
);
   always_comb begin
      if (cs_n) begin
         kind = K_DESEL;
      end else begin
         case ({ras_n, cas_n, we_n})
            3'b111:  kind = K_NOP;
            3'b011:  kind = K_ACT;
            3'b101:  kind = K_RD;
            3'b100:  kind = K_WR;
            3'b010:  kind = K_PRE;
            3'b001:  kind = K_REF;
            3'b000:  kind = K_MRS;
            default: kind = K_BST;
         endcase
      end
   end
endmodule

// File: rtl/sdcmd_judge.sv
module sdcmd_judge import sdcmd_pkg::*; #(
   parameter int NBANK = 4,
   parameter int BA_W  = 2
) (
   input  kind_t            kind,
   input  logic             cke,
   input  logic             cke_prev,
   input  pwr_t             pwr,
   input  logic [BA_W-1:0]  ba,
   input  logic             a10,
   input  logic [NBANK-1:0] bank_active,
   input  logic             ap_pend,
   input  logic [BA_W-1:0]  ap_bank,
   input  logic             busy,
   output op_t              op,
   output logic             legal,
   output logic             act_en,
   output logic             rw_en,
   output logic             rw_wr,
   output logic             rw_ap,
   output logic             pre_en,
   output logic             pre_all,
   output logic             bst_en,
   output pwr_t             pwr_nxt
);
   logic quiet, all_idle, tgt_open, tgt_pend;
   logic act_rq, rw_rq, pre_rq, bst_rq;

   always_comb begin
      quiet    = (kind == K_DESEL) || (kind == K_NOP);
      all_idle = (bank_active == '0);
      tgt_open = bank_active[ba];
      tgt_pend = ap_pend && (ap_bank == ba);
      op       = OP_DESEL;
      legal    = 1'b1;
      act_rq   = 1'b0;
      rw_rq    = 1'b0;
      pre_rq   = 1'b0;
      bst_rq   = 1'b0;
      rw_wr    = (kind == K_WR);
      rw_ap    = a10;
      pre_all  = a10;
      pwr_nxt  = pwr;
      if (!cke_prev) begin
         // low-power state: only a rising enable does anything
         if (!cke) begin
            op = OP_HOLD;
         end else begin
            pwr_nxt = PW_NORMAL;
            legal   = quiet;
            case (pwr)
               PW_SELFREF: op = OP_SREF_OUT;
               PW_SUSPEND: op = OP_SUSP_OUT;
               default:    op = OP_PD_OUT;
            endcase
         end
      end else if (!cke) begin
         // enable falling: entry into one of the low-power states
         if (kind == K_REF) begin
            op    = OP_SREF_IN;
            legal = all_idle && !busy;
         end else begin
            op    = busy ? OP_SUSP_IN : OP_PD_IN;
            legal = quiet;
         end
         if (kind == K_REF && legal) pwr_nxt = PW_SELFREF;
         else                        pwr_nxt = busy ? PW_SUSPEND : PW_PDOWN;
      end else begin
         case (kind)
            K_NOP: op = OP_NOP;
            K_ACT: begin
               op     = OP_ACT;
               legal  = !tgt_open;
               act_rq = 1'b1;
            end
            K_RD: begin
               op    = a10 ? OP_RDA : OP_RD;
               legal = tgt_open && !tgt_pend;
               rw_rq = 1'b1;
            end
            K_WR: begin
               op    = a10 ? OP_WRA : OP_WR;
               legal = tgt_open && !tgt_pend;
               rw_rq = 1'b1;
            end
            K_PRE: begin
               op     = a10 ? OP_PREA : OP_PRE;
               legal  = a10 ? !ap_pend : !tgt_pend;
               pre_rq = 1'b1;
            end
            K_REF: begin
               op    = OP_REF;
               legal = all_idle;
            end
            K_MRS: begin
               op    = OP_MRS;
               legal = all_idle;
            end
            K_BST: begin
               op     = OP_BST;
               bst_rq = 1'b1;
            end
            default: op = OP_DESEL;
         endcase
      end
      act_en = act_rq && legal;
      rw_en  = rw_rq && legal;
      pre_en = pre_rq && legal;
      bst_en = bst_rq && legal;
   end
endmodule

// File: rtl/sdcmd_power.sv
module sdcmd_power import sdcmd_pkg::*; (
   input  logic clk,
   input  logic rst_n,
   input  logic cke,
   input  pwr_t pwr_nxt,
   output pwr_t pwr,
   output logic cke_prev
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pwr      <= PW_NORMAL;
         cke_prev <= 1'b1;
      end else begin
         pwr      <= pwr_nxt;
         cke_prev <= cke;
      end
   end

   // the mode register and the stored enable level are separate flops
   p_mode_tracks_cke_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr == PW_NORMAL) == cke_prev);
endmodule

// File: rtl/sdcmd_banks.sv
module sdcmd_banks #(
   parameter int NBANK     = 4,
   parameter int BA_W      = 2,
   parameter int BURST_LEN = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   input  logic [BA_W-1:0]  ba,
   input  logic             act_en,
   input  logic             rw_en,
   input  logic             rw_wr,
   input  logic             rw_ap,
   input  logic             pre_en,
   input  logic             pre_all,
   input  logic             bst_en,
   output logic [NBANK-1:0] bank_active,
   output logic             busy,
   output logic             is_write,
   output logic             ap_pend,
   output logic [BA_W-1:0]  ap_bank
);
   localparam int CNT_W = $clog2(BURST_LEN + 1);

   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             wr_q, ap_q, last_beat, ap_done;
   logic [BA_W-1:0]  apb_q;
   logic [NBANK-1:0] act_q;

   always_comb begin
      last_beat = advance && (cnt_q == CNT_W'(1));
      ap_done   = ap_q && (last_beat || bst_en || rw_en);
      if (rw_en)                          cnt_d = CNT_W'(BURST_LEN);
      else if (bst_en)                    cnt_d = '0;
      else if (advance && cnt_q != '0)    cnt_d = cnt_q - CNT_W'(1);
      else                                cnt_d = cnt_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         wr_q  <= 1'b0;
         ap_q  <= 1'b0;
         apb_q <= '0;
      end else begin
         cnt_q <= cnt_d;
         if (rw_en) begin
            wr_q  <= rw_wr;
            ap_q  <= rw_ap;
            apb_q <= ba;
         end else if (ap_done) begin
            ap_q  <= 1'b0;
         end
      end
   end

   for (genvar i = 0; i < NBANK; i++) begin : g_bank
      logic hit, close_ap;
      assign hit      = (ba == BA_W'(i));
      assign close_ap = ap_done && (apb_q == BA_W'(i));
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                             act_q[i] <= 1'b0;
         else if (pre_en && (pre_all || hit))    act_q[i] <= 1'b0;
         else if (act_en && hit)                 act_q[i] <= 1'b1;
         else if (close_ap)                      act_q[i] <= 1'b0;
      end
   end

   assign bank_active = act_q;
   assign busy        = (cnt_q != '0);
   assign is_write    = wr_q;
   assign ap_pend     = ap_q;
   assign ap_bank     = apb_q;

   p_burst_bounded_r14: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(BURST_LEN));
   p_pending_bank_open_r8: assert property (@(posedge clk) disable iff (!rst_n)
      ap_q |-> act_q[apb_q]);
   p_suspend_freeze_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!advance && !rw_en && !bst_en) |=> $stable(cnt_q));
endmodule

// File: rtl/sdcmd_delay.sv
module sdcmd_delay #(
   parameter int LAT = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   if (LAT == 0) begin : g_direct
      assign q = d;
   end else if (LAT == 1) begin : g_one
      logic r;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) r <= 1'b0;
         else        r <= d;
      end
      assign q = r;
   end else begin : g_chain
      logic [LAT-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) sr <= '0;
         else        sr <= {sr[LAT-2:0], d};
      end
      assign q = sr[LAT-1];
   end
endmodule

// File: rtl/sdcmd_decoder.sv
module sdcmd_decoder import sdcmd_pkg::*; #(
   parameter int NBANK       = 4,
   parameter int BURST_LEN   = 4,
   parameter int RD_MASK_LAT = 2,
   parameter int WR_MASK_LAT = 0,
   localparam int BA_W       = $clog2(NBANK)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cke,
   input  logic             cs_n,
   input  logic             ras_n,
   input  logic             cas_n,
   input  logic             we_n,
   input  logic [BA_W-1:0]  ba,
   input  logic             a10,
   input  logic             dqm,
   output logic [4:0]       op_code,
   output logic             op_err,
   output logic [NBANK-1:0] bank_active,
   output logic [1:0]       pwr_state,
   output logic             burst_busy,
   output logic             rd_oe,
   output logic             wr_mask
);
   initial begin
      a_nbank_pow2: assert (NBANK >= 2 && (NBANK & (NBANK - 1)) == 0)
         else $error("NBANK must be a power of two of at least 2");
      a_burst_len: assert (BURST_LEN >= 1)
         else $error("BURST_LEN must be at least 1");
      a_mask_lat: assert (RD_MASK_LAT >= 0 && WR_MASK_LAT >= 0)
         else $error("mask latencies must not be negative");
   end

   kind_t            kind;
   op_t              op, op_q;
   pwr_t             pwr, pwr_nxt;
   logic             cke_prev, legal, err_q;
   logic             act_en, rw_en, rw_wr, rw_ap, pre_en, pre_all, bst_en;
   logic             busy, is_write, ap_pend, advance, dqm_rd, dqm_wr;
   logic [BA_W-1:0]  ap_bank;
   logic [NBANK-1:0] banks;

   sdcmd_classify u_cls (
      .cs_n(cs_n), .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .kind(kind));

   sdcmd_judge #(.NBANK(NBANK), .BA_W(BA_W)) u_judge (
      .kind(kind), .cke(cke), .cke_prev(cke_prev), .pwr(pwr), .ba(ba),
      .a10(a10), .bank_active(banks), .ap_pend(ap_pend), .ap_bank(ap_bank),
      .busy(busy), .op(op), .legal(legal), .act_en(act_en), .rw_en(rw_en),
      .rw_wr(rw_wr), .rw_ap(rw_ap), .pre_en(pre_en), .pre_all(pre_all),
      .bst_en(bst_en), .pwr_nxt(pwr_nxt));

   sdcmd_power u_pwr (
      .clk(clk), .rst_n(rst_n), .cke(cke), .pwr_nxt(pwr_nxt), .pwr(pwr),
      .cke_prev(cke_prev));

   assign advance = (pwr == PW_NORMAL) && cke;

   sdcmd_banks #(.NBANK(NBANK), .BA_W(BA_W), .BURST_LEN(BURST_LEN)) u_banks (
      .clk(clk), .rst_n(rst_n), .advance(advance), .ba(ba), .act_en(act_en),
      .rw_en(rw_en), .rw_wr(rw_wr), .rw_ap(rw_ap), .pre_en(pre_en),
      .pre_all(pre_all), .bst_en(bst_en), .bank_active(banks), .busy(busy),
      .is_write(is_write), .ap_pend(ap_pend), .ap_bank(ap_bank));

   sdcmd_delay #(.LAT(RD_MASK_LAT)) u_rd_dly (
      .clk(clk), .rst_n(rst_n), .d(dqm), .q(dqm_rd));
   sdcmd_delay #(.LAT(WR_MASK_LAT)) u_wr_dly (
      .clk(clk), .rst_n(rst_n), .d(dqm), .q(dqm_wr));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_q  <= OP_DESEL;
         err_q <= 1'b0;
      end else begin
         op_q  <= op;
         err_q <= !legal;
      end
   end

   assign op_code     = op_q;
   assign op_err      = err_q;
   assign bank_active = banks;
   assign pwr_state   = pwr;
   assign burst_busy  = busy;
   assign rd_oe       = busy && !is_write && !dqm_rd;
   assign wr_mask     = busy && is_write && dqm_wr;

   p_err_keeps_banks_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (op_err && !$past(burst_busy)) |-> $stable(bank_active));
   p_selfref_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_state == PW_SELFREF) |-> (bank_active == '0));
   p_oe_inside_read_r10: assert property (@(posedge clk) disable iff (!rst_n)
      rd_oe |-> (burst_busy && !wr_mask));
   p_hold_no_err_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (op_code == OP_HOLD) |-> !op_err);
endmodule

// File: tb/tb_sdcmd_decoder.sv
`timescale 1ns/1ps
module tb_sdcmd_decoder;
   localparam int NB = 4;
   localparam logic [3:0] C_DES = 4'b1111, C_NOP = 4'b0111, C_ACT = 4'b0011,
                          C_RD  = 4'b0101, C_WR  = 4'b0100, C_PRE = 4'b0010,
                          C_REF = 4'b0001, C_MRS = 4'b0000, C_BST = 4'b0110;

   logic clk = 1'b0, rst_n = 1'b0;
   logic cke = 1'b1, cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [1:0] ba = '0;
   logic a10 = 1'b0, dqm = 1'b0;
   logic [4:0] op_code;
   logic op_err, burst_busy, rd_oe, wr_mask;
   logic [NB-1:0] bank_active;
   logic [1:0] pwr_state;
   int total = 0, bad = 0;
   bit finished = 0;

   always #10 clk = ~clk;

   sdcmd_decoder #(.NBANK(NB), .BURST_LEN(4), .RD_MASK_LAT(2), .WR_MASK_LAT(0)) dut (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10), .dqm(dqm),
      .op_code(op_code), .op_err(op_err), .bank_active(bank_active),
      .pwr_state(pwr_state), .burst_busy(burst_busy), .rd_oe(rd_oe),
      .wr_mask(wr_mask));

   task automatic chk(input string tag, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   task automatic drive(input logic [3:0] c, input int b, input logic ap,
                        input logic en, input logic m);
      @(negedge clk);
      {cs_n, ras_n, cas_n, we_n} = c;
      ba  = 2'(b);
      a10 = ap;
      cke = en;
      dqm = m;
   endtask

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic issue(input logic [3:0] c, input int b, input logic ap,
                        input logic en, input logic m);
      drive(c, b, ap, en, m);
      tick();
   endtask

   task automatic expect_st(input string tag, input int op, input int err, input int banks);
      chk({tag, " op"}, op_code, op);
      chk({tag, " err"}, op_err, err);
      chk({tag, " banks"}, bank_active, banks);
   endtask

   task automatic t_reset();
      #5;
      chk("R13 op", op_code, 0);
      chk("R13 err", op_err, 0);
      chk("R13 banks", bank_active, 0);
      chk("R13 pwr", pwr_state, 0);
      chk("R13 busy", burst_busy, 0);
      chk("R13 oe", rd_oe, 0);
      chk("R13 mask", wr_mask, 0);
   endtask

   task automatic t_bank_rules();
      issue(C_ACT, 1, 0, 1, 0); expect_st("R1 act", 2, 0, 4'b0010);
      issue(C_RD, 2, 0, 1, 0);  expect_st("R2 rd idle bank", 3, 1, 4'b0010);
      issue(C_ACT, 1, 0, 1, 0); expect_st("R2 act open bank", 2, 1, 4'b0010);
      issue(C_NOP, 0, 0, 1, 0); expect_st("R12 err clears", 1, 0, 4'b0010);
      issue(C_DES, 0, 0, 1, 0); chk("R1 deselect op", op_code, 0);
      issue(C_WR, 1, 0, 1, 0);  expect_st("R1 wr", 5, 0, 4'b0010);
      chk("R14 busy after wr", burst_busy, 1);
      for (int k = 0; k < 3; k++) begin
         issue(C_NOP, 0, 0, 1, 0);
         chk("R14 busy mid burst", burst_busy, 1);
      end
      issue(C_NOP, 0, 0, 1, 0);
      chk("R14 busy ends", burst_busy, 0);
   endtask

   task automatic t_refresh();
      issue(C_REF, 0, 0, 1, 0); expect_st("R3 ref with open bank", 9, 1, 4'b0010);
      issue(C_PRE, 1, 0, 1, 0); expect_st("R7 pre one bank", 7, 0, 4'b0000);
      issue(C_REF, 0, 0, 1, 0); expect_st("R3 ref idle", 9, 0, 4'b0000);
   endtask

   task automatic t_mode_set();
      issue(C_ACT, 0, 0, 1, 0);
      issue(C_ACT, 3, 0, 1, 0); expect_st("R2 second act", 2, 0, 4'b1001);
      issue(C_MRS, 0, 0, 1, 0); expect_st("R9 mrs with open", 10, 1, 4'b1001);
      issue(C_PRE, 0, 1, 1, 0); expect_st("R7 pre all", 8, 0, 4'b0000);
      issue(C_MRS, 0, 0, 1, 0); expect_st("R9 mrs idle", 10, 0, 4'b0000);
   endtask

   task automatic t_autopre();
      issue(C_ACT, 2, 0, 1, 0);
      issue(C_RD, 2, 1, 1, 0);  expect_st("R8 rda", 4, 0, 4'b0100);
      issue(C_WR, 2, 0, 1, 0);  expect_st("R8 wr to pending bank", 5, 1, 4'b0100);
      issue(C_NOP, 0, 0, 1, 0); chk("R8 bank open", bank_active, 4'b0100);
      issue(C_NOP, 0, 0, 1, 0); chk("R8 bank open late", bank_active, 4'b0100);
      issue(C_NOP, 0, 0, 1, 0);
      chk("R8 bank closed at burst end", bank_active, 4'b0000);
      chk("R8 busy end", burst_busy, 0);
   endtask

   task automatic t_burst_stop();
      issue(C_ACT, 0, 0, 1, 0);
      issue(C_RD, 0, 0, 1, 0);  chk("R14 rd busy", burst_busy, 1);
      issue(C_BST, 0, 0, 1, 0); expect_st("R14 bst", 11, 0, 4'b0001);
      chk("R14 bst ends burst", burst_busy, 0);
      issue(C_PRE, 0, 0, 1, 0); chk("R7 close b0", bank_active, 0);
   endtask

   task automatic t_selfref();
      issue(C_REF, 0, 0, 0, 0); expect_st("R4 sref entry", 12, 0, 0);
      chk("R4 pwr sref", pwr_state, 3);
      issue(C_ACT, 1, 0, 0, 0); expect_st("R5 hold ignores act", 18, 0, 0);
      chk("R5 pwr stays", pwr_state, 3);
      issue(C_NOP, 0, 0, 1, 0); expect_st("R5 sref exit", 13, 0, 0);
      chk("R5 pwr normal", pwr_state, 0);
      issue(C_ACT, 1, 0, 1, 0);
      issue(C_REF, 0, 0, 0, 0); expect_st("R4 sref with open bank", 12, 1, 4'b0010);
      chk("R4 fallback pdown", pwr_state, 1);
      issue(C_ACT, 1, 0, 1, 0); expect_st("R5 exit with act", 15, 1, 4'b0010);
      chk("R5 exit pwr", pwr_state, 0);
      issue(C_PRE, 1, 0, 1, 0); chk("R7 close b1", bank_active, 0);
   endtask

   task automatic t_pdown_suspend();
      issue(C_NOP, 0, 0, 0, 0); expect_st("R6 pd entry", 14, 0, 0);
      chk("R6 pwr pd", pwr_state, 1);
      issue(C_NOP, 0, 0, 1, 0); expect_st("R5 pd exit", 15, 0, 0);
      issue(C_ACT, 3, 0, 1, 0);
      issue(C_RD, 3, 0, 1, 0);
      issue(C_NOP, 0, 0, 1, 0);
      issue(C_DES, 0, 0, 0, 0); expect_st("R6 suspend entry", 16, 0, 4'b1000);
      chk("R6 pwr suspend", pwr_state, 2);
      for (int k = 0; k < 2; k++) begin
         issue(C_NOP, 0, 0, 0, 0);
         chk("R6 frozen busy", burst_busy, 1);
      end
      issue(C_NOP, 0, 0, 1, 0); expect_st("R5 suspend exit", 17, 0, 4'b1000);
      chk("R6 busy after exit", burst_busy, 1);
      issue(C_NOP, 0, 0, 1, 0); chk("R6 resumed 2", burst_busy, 1);
      issue(C_NOP, 0, 0, 1, 0); chk("R6 resumed 1", burst_busy, 1);
      issue(C_NOP, 0, 0, 1, 0); chk("R6 resumed done", burst_busy, 0);
      issue(C_PRE, 3, 0, 1, 0);
   endtask

   task automatic t_dqm_read();
      issue(C_ACT, 0, 0, 1, 0);
      issue(C_RD, 0, 0, 1, 0);  chk("R10 oe first", rd_oe, 1);
      issue(C_NOP, 0, 0, 1, 1); chk("R10 oe before latency", rd_oe, 1);
      chk("R11 no mask on read", wr_mask, 0);
      issue(C_NOP, 0, 0, 1, 0); chk("R10 oe masked", rd_oe, 0);
      issue(C_NOP, 0, 0, 1, 0); chk("R10 oe back", rd_oe, 1);
      issue(C_NOP, 0, 0, 1, 0); chk("R10 oe after burst", rd_oe, 0);
   endtask

   task automatic t_dqm_write();
      issue(C_WR, 0, 0, 1, 0);
      drive(C_NOP, 0, 0, 1, 1); #1; chk("R11 mask same cycle", wr_mask, 1);
      chk("R10 no oe on write", rd_oe, 0);
      tick();
      drive(C_NOP, 0, 0, 1, 0); #1; chk("R11 mask released", wr_mask, 0);
      tick();
      drive(C_NOP, 0, 0, 1, 1); #1; chk("R11 mask again", wr_mask, 1);
      tick();
      issue(C_NOP, 0, 0, 1, 0);
      drive(C_NOP, 0, 0, 1, 1); #1; chk("R11 no mask outside burst", wr_mask, 0);
      tick();
      issue(C_PRE, 0, 0, 1, 0); chk("R7 final close", bank_active, 0);
   endtask

   initial begin
      t_reset();
      repeat (2) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      issue(C_NOP, 0, 0, 1, 0);
      t_bank_rules();
      t_refresh();
      t_mode_set();
      t_autopre();
      t_burst_stop();
      t_selfref();
      t_pdown_suspend();
      t_dqm_read();
      t_dqm_write();
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(20 * 100000);
      if (!finished) begin
         total++;
         bad++;
         $display("FAIL watchdog R12 actual=hung expected=complete");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule